// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block holds a small bank of one-bit semaphore tokens that two independent ports share. Each port uses them to claim shared resources. A port asks for a token by writing 0 to it and gives it back by writing 1. Each port then reads back its own view of the token: 0 means "this side owns it" and 1 means "free, or held by the other side".

A request that arrives while the other side holds the token is not lost. It stays pending, and ownership passes to the waiting side on the clock edge where the owner writes its release. A pending request can be withdrawn by writing 1.

Semaphore accesses are qualified by a dedicated select. An access that also raises the memory enable is an illegal combination and is dropped. Read results are captured in a per-port register, so the value a port has read stays put while the other port keeps writing.

Top module: `sem_bank_top`

## Requirements
- R1: The token is picked by the low 3 bits of a port's address; all higher address bits have no effect on which token is accessed.
- R2: A write uses only data bit 0: bit 0 = 0 requests the token, bit 0 = 1 releases it or withdraws a pending request; all other data bits are ignored.
- R3: A free token reads as 1 on both ports; a token owned by one port reads 0 on that port and 1 on the other.
- R4: While one port owns a token, a request (write of 0) from the other port leaves both views unchanged.
- R5: A request made by the non-owner is kept; when the owner writes 1, the waiting port owns the token from the next clock edge.
- R6: A write of 1 by the port that does not own the token cancels its pending request, so a later release by the owner leaves the token free.
- R7: A read returns the token's view replicated on every data bit (all ones or all zeros), registered on the clock edge of the read strobe; the read output holds its value between reads of that port, whatever the other port does.
- R8: An access made while the port's memory enable is high is rejected: the write does not change any token and the read output keeps its previous value.
- R9: When both ports request the same free token on the same clock edge, the left port wins, and the right port's request stays pending.
- R10: After reset every token is free and both read outputs are all ones.
- R11: Each token is independent: an access to one token does not change any other token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| l_sel_i | input | 1 | Left port semaphore select |
| l_mem_en_i | input | 1 | Left port memory enable; a semaphore access is rejected while it is high |
| l_addr_i | input | ADDR_W (14) | Left port address; low 3 bits pick the token |
| l_wr_i | input | 1 | Left port write strobe |
| l_rd_i | input | 1 | Left port read strobe |
| l_wdata_i | input | DATA_W (16) | Left port write data; only bit 0 is used |
| l_rdata_o | output | DATA_W (16) | Left port registered read data |
| r_sel_i | input | 1 | Right port semaphore select |
| r_mem_en_i | input | 1 | Right port memory enable; a semaphore access is rejected while it is high |
| r_addr_i | input | ADDR_W (14) | Right port address; low 3 bits pick the token |
| r_wr_i | input | 1 | Right port write strobe |
| r_rd_i | input | 1 | Right port read strobe |
| r_wdata_i | input | DATA_W (16) | Right port write data; only bit 0 is used |
| r_rdata_o | output | DATA_W (16) | Right port registered read data |

## Verification
The embedded assertions check the per-token ownership rules on every cycle:
- the owner keeps the token against requests from the other side;
- a release hands the token to a waiting requester;
- a simultaneous request resolves to the left port;
- a withdrawn request is cleared;
- read outputs are always uniform and only move on a read strobe;
- a rejected access leaves the output alone.

Some behaviour can only be shown by the directed scenarios, because it concerns what a port observes over a chain of operations:
- that the upper address bits and upper data bits truly have no effect;
- the reset view;
- the full request, hand-over and cancel sequences;
- the independence of neighbouring tokens.

// File: rtl/sem_pkg.sv
package sem_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'b00,
    OWN_LEFT  = 2'b01,
    OWN_RIGHT = 2'b10
  } own_e;
endpackage

// File: rtl/sem_port.sv
module sem_port #(
  parameter int NUM_SEM = 8,
  localparam int IDX_W = $clog2(NUM_SEM)
) (
  input  logic               sel_i,
  input  logic               mem_en_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic               wr_i,
  input  logic               rd_i,
  input  logic               wbit_i,
  output logic [NUM_SEM-1:0] req_o,
  output logic [NUM_SEM-1:0] rel_o,
  output logic               rd_en_o
);
  logic acc;
  // semaphore select together with memory enable is illegal
  assign acc     = sel_i & ~mem_en_i;
  assign rd_en_o = acc & rd_i;

  for (genvar i = 0; i < NUM_SEM; i++) begin : g_dec
    logic hit;
    assign hit      = acc & wr_i & (idx_i == IDX_W'(i));
    assign req_o[i] = hit & ~wbit_i;
    assign rel_o[i] = hit &  wbit_i;
  end
endmodule

// File: rtl/sem_cell.sv
module sem_cell
  import sem_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic l_req_i,
  input  logic l_rel_i,
  input  logic r_req_i,
  input  logic r_rel_i,
  output logic l_view_o,
  output logic r_view_o
);
  own_e owner_q, owner_d;
  logic want_l_q, want_r_q, want_l_d, want_r_d;

  always_comb begin
    want_l_d = l_req_i ? 1'b1 : (l_rel_i ? 1'b0 : want_l_q);
    want_r_d = r_req_i ? 1'b1 : (r_rel_i ? 1'b0 : want_r_q);
    owner_d  = owner_q;
    unique case (owner_q)
      OWN_LEFT:  if (!want_l_d) owner_d = want_r_d ? OWN_RIGHT : OWN_NONE;
      OWN_RIGHT: if (!want_r_d) owner_d = want_l_d ? OWN_LEFT : OWN_NONE;
      default: begin
        // fixed priority on a tie: left first
        if (want_l_d)      owner_d = OWN_LEFT;
        else if (want_r_d) owner_d = OWN_RIGHT;
        else               owner_d = OWN_NONE;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owner_q  <= OWN_NONE;
      want_l_q <= 1'b0;
      want_r_q <= 1'b0;
    end else begin
      owner_q  <= owner_d;
      want_l_q <= want_l_d;
      want_r_q <= want_r_d;
    end
  end

  assign l_view_o = (owner_q != OWN_LEFT);
  assign r_view_o = (owner_q != OWN_RIGHT);

  AST_OWNER_HOLDS_L: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q == OWN_LEFT && !l_rel_i) |=> owner_q == OWN_LEFT); // R4
  AST_OWNER_HOLDS_R: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q == OWN_RIGHT && !r_rel_i) |=> owner_q == OWN_RIGHT); // R4
  AST_HANDOVER_LR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q == OWN_LEFT && l_rel_i && want_r_q && !r_rel_i) |=> owner_q == OWN_RIGHT); // R5
  AST_HANDOVER_RL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q == OWN_RIGHT && r_rel_i && want_l_q && !l_rel_i) |=> owner_q == OWN_LEFT); // R5
  AST_TIE_LEFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q == OWN_NONE && l_req_i && r_req_i) |=> (owner_q == OWN_LEFT && want_r_q)); // R9
  AST_CANCEL_R: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q == OWN_LEFT && r_rel_i && !l_rel_i) |=> (!want_r_q && owner_q == OWN_LEFT)); // R6
endmodule

// File: rtl/sem_rdreg.sv
module sem_rdreg #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic              view_i,
  output logic [DATA_W-1:0] rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '1;
    else if (rd_en_i) rdata_o <= {DATA_W{view_i}};
  end

  AST_RD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o)); // R7
  AST_RD_UNIFORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(rdata_o) == 0) || ($countones(rdata_o) == DATA_W)); // R7
endmodule

// File: rtl/sem_bank_top.sv
module sem_bank_top #(
  parameter int NUM_SEM = 8,
  parameter int ADDR_W  = 14,
  parameter int DATA_W  = 16,
  localparam int IDX_W  = $clog2(NUM_SEM)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              l_sel_i,
  input  logic              l_mem_en_i,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic              l_wr_i,
  input  logic              l_rd_i,
  input  logic [DATA_W-1:0] l_wdata_i,
  output logic [DATA_W-1:0] l_rdata_o,
  input  logic              r_sel_i,
  input  logic              r_mem_en_i,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic              r_wr_i,
  input  logic              r_rd_i,
  input  logic [DATA_W-1:0] r_wdata_i,
  output logic [DATA_W-1:0] r_rdata_o
);
  logic [NUM_SEM-1:0] l_req, l_rel, r_req, r_rel;
  logic [NUM_SEM-1:0] l_view, r_view;
  logic               l_rd_en, r_rd_en;
  logic [IDX_W-1:0]   l_idx, r_idx;
  logic               unused_hi_bits;

  assign l_idx = l_addr_i[IDX_W-1:0];
  assign r_idx = r_addr_i[IDX_W-1:0];
  assign unused_hi_bits = ^{l_addr_i[ADDR_W-1:IDX_W], r_addr_i[ADDR_W-1:IDX_W],
                            l_wdata_i[DATA_W-1:1], r_wdata_i[DATA_W-1:1]};

  sem_port #(.NUM_SEM(NUM_SEM)) u_port_l (
    .sel_i(l_sel_i), .mem_en_i(l_mem_en_i), .idx_i(l_idx), .wr_i(l_wr_i),
    .rd_i(l_rd_i), .wbit_i(l_wdata_i[0]), .req_o(l_req), .rel_o(l_rel),
    .rd_en_o(l_rd_en));

  sem_port #(.NUM_SEM(NUM_SEM)) u_port_r (
    .sel_i(r_sel_i), .mem_en_i(r_mem_en_i), .idx_i(r_idx), .wr_i(r_wr_i),
    .rd_i(r_rd_i), .wbit_i(r_wdata_i[0]), .req_o(r_req), .rel_o(r_rel),
    .rd_en_o(r_rd_en));

  for (genvar i = 0; i < NUM_SEM; i++) begin : g_sem
    sem_cell u_cell (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .l_req_i(l_req[i]), .l_rel_i(l_rel[i]),
      .r_req_i(r_req[i]), .r_rel_i(r_rel[i]),
      .l_view_o(l_view[i]), .r_view_o(r_view[i]));
  end

  sem_rdreg #(.DATA_W(DATA_W)) u_rd_l (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_en_i(l_rd_en),
    .view_i(l_view[l_idx]), .rdata_o(l_rdata_o));

  sem_rdreg #(.DATA_W(DATA_W)) u_rd_r (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_en_i(r_rd_en),
    .view_i(r_view[r_idx]), .rdata_o(r_rdata_o));

  AST_REJECT_L: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l_mem_en_i |=> $stable(l_rdata_o)); // R8
  AST_REJECT_R: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r_mem_en_i |=> $stable(r_rdata_o)); // R8
  AST_NO_DUAL_OWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_view | r_view) == {NUM_SEM{1'b1}}); // R3
endmodule

// File: tb/sem_bank_top_tb.sv
module sem_bank_top_tb;
  localparam int AW = 14;
  localparam int DW = 16;
  localparam logic [DW-1:0] ONES = '1;
  localparam logic [DW-1:0] ZERO = '0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l_sel = 0, l_mem = 0, l_wr = 0, l_rd = 0;
  logic r_sel = 0, r_mem = 0, r_wr = 0, r_rd = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_wd = '0, r_wd = '0;
  logic [DW-1:0] l_rdata, r_rdata;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sem_bank_top u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .l_sel_i(l_sel), .l_mem_en_i(l_mem), .l_addr_i(l_addr), .l_wr_i(l_wr),
    .l_rd_i(l_rd), .l_wdata_i(l_wd), .l_rdata_o(l_rdata),
    .r_sel_i(r_sel), .r_mem_en_i(r_mem), .r_addr_i(r_addr), .r_wr_i(r_wr),
    .r_rd_i(r_rd), .r_wdata_i(r_wd), .r_rdata_o(r_rdata));

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    l_sel = 0; l_wr = 0; l_rd = 0; l_mem = 0;
    r_sel = 0; r_wr = 0; r_rd = 0; r_mem = 0;
  endtask

  // side 0 = left, 1 = right
  task automatic wr(bit side, logic [AW-1:0] a, logic [DW-1:0] d, bit mem = 0);
    @(negedge clk);
    if (!side) begin l_sel = 1; l_wr = 1; l_addr = a; l_wd = d; l_mem = mem; end
    else       begin r_sel = 1; r_wr = 1; r_addr = a; r_wd = d; r_mem = mem; end
    @(posedge clk);
    idle();
  endtask

  task automatic rd(bit side, logic [AW-1:0] a, output logic [DW-1:0] q, input bit mem = 0);
    @(negedge clk);
    if (!side) begin l_sel = 1; l_rd = 1; l_addr = a; l_mem = mem; end
    else       begin r_sel = 1; r_rd = 1; r_addr = a; r_mem = mem; end
    @(posedge clk);
    #1;
    q = side ? r_rdata : l_rdata;
    idle();
  endtask

  task automatic t_reset();
    logic [DW-1:0] q;
    check("R10 left out", l_rdata, ONES);
    check("R10 right out", r_rdata, ONES);
    for (int i = 0; i < 8; i++) begin
      rd(0, AW'(i), q); check("R10/R3 left free", q, ONES);
      rd(1, AW'(i), q); check("R10/R3 right free", q, ONES);
    end
  endtask

  task automatic t_take_views();
    logic [DW-1:0] q;
    wr(0, 14'd0, ZERO);
    rd(0, 14'd0, q); check("R3 left owner", q, ZERO);
    rd(1, 14'd0, q); check("R3 right non-owner", q, ONES);
    rd(0, 14'd1, q); check("R11 neighbour untouched", q, ONES);
    wr(0, 14'd0, 16'h0001);
    wr(1, 14'd1, ZERO);
    rd(1, 14'd1, q); check("R3 right owner", q, ZERO);
    rd(0, 14'd1, q); check("R3 left non-owner", q, ONES);
    rd(0, 14'd0, q); check("R3 released free", q, ONES);
    wr(1, 14'd1, 16'h0001);
  endtask

  task automatic t_hold_handover();
    logic [DW-1:0] q;
    wr(0, 14'd2, ZERO);
    wr(1, 14'd2, ZERO);
    rd(1, 14'd2, q); check("R4 right still blocked", q, ONES);
    rd(0, 14'd2, q); check("R4 left keeps", q, ZERO);
    wr(0, 14'd2, 16'h0001);
    rd(1, 14'd2, q); check("R5 right gets token", q, ZERO);
    rd(0, 14'd2, q); check("R5 left sees other owner", q, ONES);
    wr(1, 14'd2, 16'h0001);
    rd(1, 14'd2, q); check("R5 free after release", q, ONES);
  endtask

  task automatic t_cancel();
    logic [DW-1:0] q;
    wr(1, 14'd3, ZERO);
    wr(0, 14'd3, ZERO);
    wr(0, 14'd3, 16'h0001);
    rd(1, 14'd3, q); check("R6 right keeps after left cancel", q, ZERO);
    wr(1, 14'd3, 16'h0001);
    rd(0, 14'd3, q); check("R6 left not granted", q, ONES);
    rd(1, 14'd3, q); check("R6 token free", q, ONES);
  endtask

  task automatic t_bit0_addr();
    logic [DW-1:0] q;
    wr(0, 14'h3FFC, 16'hFFFE);
    rd(0, 14'h0004, q); check("R1/R2 request via bit0=0, high bits set", q, ZERO);
    rd(0, 14'h1554, q); check("R1 alias by low bits", q, ZERO);
    rd(0, 14'h0005, q); check("R11 index 5 untouched", q, ONES);
    wr(0, 14'h2004, 16'h0001);
    rd(0, 14'd4, q); check("R2 release via bit0=1", q, ONES);
    rd(1, 14'd4, q); check("R2 right view free", q, ONES);
  endtask

  task automatic t_read_reg();
    logic [DW-1:0] q;
    rd(1, 14'd5, q); check("R7 right reads all ones", q, ONES);
    wr(0, 14'd5, ZERO);
    wr(1, 14'd5, ZERO);
    #1; check("R7 right output held", r_rdata, ONES);
    rd(0, 14'd5, q); check("R7 left reads all zeros", q, ZERO);
    wr(0, 14'd5, 16'h0001);
    #1; check("R7 left output held after handover", l_rdata, ZERO);
    rd(1, 14'd5, q); check("R7/R5 right owns", q, ZERO);
    wr(1, 14'd5, 16'h0001);
  endtask

  task automatic t_reject();
    logic [DW-1:0] q;
    wr(0, 14'd6, ZERO, 1'b1);
    rd(0, 14'd6, q); check("R8 rejected write ignored", q, ONES);
    wr(0, 14'd6, ZERO);
    rd(0, 14'd6, q, 1'b1); check("R8 rejected read holds output", q, ONES);
    rd(0, 14'd6, q); check("R8 normal read after", q, ZERO);
    wr(0, 14'd6, 16'h0001);
  endtask

  task automatic t_tie();
    logic [DW-1:0] q;
    @(negedge clk);
    l_sel = 1; l_wr = 1; l_addr = 14'd7; l_wd = ZERO;
    r_sel = 1; r_wr = 1; r_addr = 14'd7; r_wd = ZERO;
    @(posedge clk);
    idle();
    rd(0, 14'd7, q); check("R9 left wins tie", q, ZERO);
    rd(1, 14'd7, q); check("R9 right loses tie", q, ONES);
    wr(0, 14'd7, 16'h0001);
    rd(1, 14'd7, q); check("R9/R5 right request kept", q, ZERO);
    wr(1, 14'd7, 16'h0001);
    rd(0, 14'd7, q); check("R9 free at end", q, ONES);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_take_views();
    t_hold_handover();
    t_cancel();
    t_bit0_addr();
    t_read_reg();
    t_reject();
    t_tie();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end
endmodule